// File: doc/BRIEF.md
# EOI Storm Throttle for a Level-Triggered Interrupt Router

This block sits on the end-of-interrupt path of a 24-input interrupt router whose inputs are level sensitive. Each input pin has a routing entry with an 8-bit vector, a trigger-mode bit (1 = level), a mask bit (1 = masked) and a remote-in-service flag. When the processor side broadcasts an EOI for a vector, the block checks every pin in one cycle. On each level pin whose vector matches and whose in-service flag is set, it drops the flag. If the line is still requesting and the pin is unmasked, it asks for the interrupt to be delivered again.

Some interrupt handlers acknowledge before they remove the cause, so a line can stay asserted through a long run of EOIs. Each pin counts the EOIs in a row that find its line still requesting. When that count reaches a threshold, the block stops re-delivering at once. It clears the count and arms a one-shot delay timer instead. The service request is raised when the timer expires. Entry fields are loaded through a minimal write strobe. The delivery logic downstream sets a pin's in-service flag with a pulse on `rirr_set`.

Top module: `eoi_throttle_ctrl`

## Requirements
- R1: An EOI acts only on pins whose stored vector equals `eoi_vec` and whose trigger bit is 1 (level). On any other pin the in-service flag and the storm count are left unchanged.
- R2: A matching level pin whose in-service flag is already clear is left untouched. It raises no service request and its storm count keeps its value.
- R3: On a matching level pin with the in-service flag set, the flag is cleared. `rirr_out` shows the cleared flag in the cycle after the EOI cycle. All matching pins are cleared by the same EOI, in the same cycle.
- R4: If such a pin is unmasked (mask bit 0) and its `req_pend` bit is 1, its count goes up by one and `service_req` pulses for one cycle in the cycle after the EOI. Otherwise its count returns to zero and no request is raised.
- R5: When the incremented count reaches `STORM_LIMIT`, the count returns to zero and no immediate request is raised. Instead, `storm_event` pulses in the cycle after the EOI and the delay timer is armed.
- R6: An armed timer raises a one-cycle `service_req` exactly `DELAY_CYCLES` clock cycles after the `storm_event` pulse.
- R7: Arming the timer while it is already pending keeps the earlier expiry, and only one delayed request results.
- R8: Storm counts are kept per pin, independent of the vector value. Vectors of 24 and above work like any other vector.
- R9: After reset, every entry is masked with vector 0 and edge trigger, every in-service flag and count is zero, the timer is idle, and all outputs are low.
- R10: `ent_wr` loads the vector and trigger bit of pin `ent_pin`. `msk_wr` loads the mask bit of pin `msk_pin`. `rirr_set[i]` sets the in-service flag of pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ent_wr | input | 1 | Load vector and trigger bit of one entry |
| ent_pin | input | PIN_W (5) | Entry index for `ent_wr` |
| ent_vec | input | VEC_W (8) | Vector to store |
| ent_level | input | 1 | Trigger bit to store, 1 = level |
| msk_wr | input | 1 | Load mask bit of one entry |
| msk_pin | input | PIN_W (5) | Entry index for `msk_wr` |
| msk_val | input | 1 | Mask value, 1 = masked |
| rirr_set | input | NUM_PINS (24) | Per-pin pulse that sets the in-service flag |
| req_pend | input | NUM_PINS (24) | Raw request level of each pin |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vec | input | VEC_W (8) | Vector carried by the EOI |
| service_req | output | 1 | One-cycle request to redeliver pending interrupts |
| storm_event | output | 1 | One-cycle pulse when a delayed redelivery is scheduled |
| timer_pending | output | 1 | Delay timer is armed |
| rirr_out | output | NUM_PINS (24) | Current in-service flags |

## Verification
Some properties are checked by assertions on every cycle:
- skipped pins keep their in-service flag;
- a matching flagged pin is cleared;
- a count never reaches the threshold;
- a masked pin never asks for redelivery;
- a pending timer counts down without being reloaded;
- each storm event either leaves the timer armed or coincides with its firing.

Other behaviour only the bench scenarios can show:
- the exact count sequence that leads to deferral;
- that a count survives an EOI which finds the flag clear;
- the delay measured in cycles;
- that two storms close together produce one delayed request.

// File: rtl/eoi_thr_pkg.sv
// Shared types for the EOI storm throttle.
// Assumes: one scan action per pin per cycle.
package eoi_thr_pkg;
    typedef enum logic [1:0] {
        EA_NONE      = 2'd0,  // pin not acted on
        EA_CLEAR     = 2'd1,  // flag dropped, count reset
        EA_REDELIVER = 2'd2,  // flag dropped, immediate redelivery
        EA_DEFER     = 2'd3   // flag dropped, storm threshold reached
    } eoi_act_e;
endpackage

// File: rtl/eoi_pin_slice.sv
// One input pin: routing entry fields, in-service flag and storm count.
// Decides in one cycle what an EOI does to this pin.
// Assumes: eoi_valid is a one-cycle strobe; LIMIT >= 1.
module eoi_pin_slice
    import eoi_thr_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int LIMIT = 10000,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_wr,
    input  logic [VEC_W-1:0] ent_vec,
    input  logic             ent_level,
    input  logic             msk_wr,
    input  logic             msk_val,
    input  logic             rirr_set,
    input  logic             req_pend,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vec,
    output logic             rirr_o,
    output logic             imm_o,
    output logic             storm_o
);
    logic [VEC_W-1:0] vec_q;
    logic             level_q;
    logic             mask_q;
    logic             rirr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;
    eoi_act_e         act;

    // Classify the effect of the current EOI on this pin.
    always_comb begin
        hit     = eoi_valid && (vec_q == eoi_vec) && level_q && rirr_q;
        cnt_nxt = cnt_q + 1'b1;
        act     = EA_NONE;
        if (hit) begin
            if (!mask_q && req_pend)
                act = (cnt_nxt >= CNT_W'(LIMIT)) ? EA_DEFER : EA_REDELIVER;
            else
                act = EA_CLEAR;
        end
    end

    // Entry fields, in-service flag and successive-EOI count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            level_q <= 1'b0;
            mask_q  <= 1'b1;
            rirr_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (ent_wr) begin
                vec_q   <= ent_vec;
                level_q <= ent_level;
            end
            if (msk_wr)
                mask_q <= msk_val;
            rirr_q <= rirr_set | (rirr_q & ~hit);
            case (act)
                EA_REDELIVER: cnt_q <= cnt_nxt;
                EA_CLEAR,
                EA_DEFER:     cnt_q <= '0;
                default:      cnt_q <= cnt_q;
            endcase
        end
    end

    assign rirr_o  = rirr_q;
    assign imm_o   = (act == EA_REDELIVER);
    assign storm_o = (act == EA_DEFER);

    // R1: a pin that does not match keeps its in-service flag
    assert_skip_keeps_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid && ((eoi_vec != vec_q) || !level_q) && !rirr_set
        |=> rirr_q == $past(rirr_q));

    // R3: a matching flagged level pin is cleared
    assert_clear_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid && (eoi_vec == vec_q) && level_q && rirr_q && !rirr_set
        |=> !rirr_q);

    // R5: the count is always reset before it reaches the threshold
    assert_cnt_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LIMIT));

    // R4: a masked pin never asks for delivery
    assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !imm_o && !storm_o);
endmodule

// File: rtl/eoi_defer_timer.sv
// One-shot delay timer. Arming while idle starts a countdown of DELAY
// cycles. Arming while pending is ignored, so the earlier expiry is kept.
// An arm in the firing cycle is absorbed by that firing.
// Assumes: DELAY >= 1.
module eoi_defer_timer #(
    parameter int DELAY = 1000000,
    localparam int TW = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic pending_o,
    output logic fire_o
);
    logic [TW-1:0] cnt_q;

    // Countdown and single-cycle expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_o <= 1'b0;
            cnt_q     <= '0;
            fire_o    <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (pending_o) begin
                if (cnt_q == '0) begin
                    pending_o <= 1'b0;
                    fire_o    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (arm) begin
                pending_o <= 1'b1;
                cnt_q     <= TW'(DELAY - 1);
            end
        end
    end

    // R7: a running countdown is never reloaded by a new arm
    assert_keep_earlier_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o && (cnt_q != '0) |=> pending_o && (cnt_q == $past(cnt_q) - 1'b1));

    // R6: arming an idle timer makes it pending
    assert_arm_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o && arm |=> pending_o);

    // R6: the expiry pulse lasts one cycle
    assert_fire_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
endmodule

// File: rtl/eoi_throttle_ctrl.sv
// EOI storm throttle: scans all pins on an EOI in one cycle, redelivers
// still-pending level interrupts at once, and defers redelivery through a
// one-shot timer once a pin's successive-EOI count hits STORM_LIMIT.
// Assumes: eoi_valid strobes are single-cycle; outputs are registered.
module eoi_throttle_ctrl
    import eoi_thr_pkg::*;
#(
    parameter int NUM_PINS     = 24,
    parameter int VEC_W        = 8,
    parameter int STORM_LIMIT  = 10000,
    parameter int DELAY_CYCLES = 1000000,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ent_wr,
    input  logic [PIN_W-1:0]    ent_pin,
    input  logic [VEC_W-1:0]    ent_vec,
    input  logic                ent_level,
    input  logic                msk_wr,
    input  logic [PIN_W-1:0]    msk_pin,
    input  logic                msk_val,
    input  logic [NUM_PINS-1:0] rirr_set,
    input  logic [NUM_PINS-1:0] req_pend,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vec,
    output logic                service_req,
    output logic                storm_event,
    output logic                timer_pending,
    output logic [NUM_PINS-1:0] rirr_out
);
    logic [NUM_PINS-1:0] imm_vec;
    logic [NUM_PINS-1:0] storm_vec;
    logic                imm_q;
    logic                fire;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        eoi_pin_slice #(
            .VEC_W (VEC_W),
            .LIMIT (STORM_LIMIT)
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .ent_wr    (ent_wr && (ent_pin == PIN_W'(i))),
            .ent_vec   (ent_vec),
            .ent_level (ent_level),
            .msk_wr    (msk_wr && (msk_pin == PIN_W'(i))),
            .msk_val   (msk_val),
            .rirr_set  (rirr_set[i]),
            .req_pend  (req_pend[i]),
            .eoi_valid (eoi_valid),
            .eoi_vec   (eoi_vec),
            .rirr_o    (rirr_out[i]),
            .imm_o     (imm_vec[i]),
            .storm_o   (storm_vec[i])
        );
    end

    eoi_defer_timer #(
        .DELAY (DELAY_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (|storm_vec),
        .pending_o (timer_pending),
        .fire_o    (fire)
    );

    // Register the combined immediate and storm outcomes of the scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_q       <= 1'b0;
            storm_event <= 1'b0;
        end else begin
            imm_q       <= |imm_vec;
            storm_event <= |storm_vec;
        end
    end

    assign service_req = imm_q | fire;

    // R5: each storm leaves the timer armed, or meets its firing
    assert_storm_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        storm_event |-> timer_pending || service_req);

    // R9: nothing is raised in the first cycle after reset
    assert_quiet_after_reset_R9: assert property (@(posedge clk)
        !rst_n |=> !service_req && !storm_event && !timer_pending);
endmodule

// File: tb/test_eoi_throttle_ctrl.sv
module test_eoi_throttle_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 24;
    localparam int LIM = 4;
    localparam int DLY = 16;
    localparam int PW  = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ent_wr = 1'b0;
    logic [PW-1:0] ent_pin = '0;
    logic [7:0]    ent_vec = '0;
    logic          ent_level = 1'b0;
    logic          msk_wr = 1'b0;
    logic [PW-1:0] msk_pin = '0;
    logic          msk_val = 1'b0;
    logic [NP-1:0] rirr_set = '0;
    logic [NP-1:0] req_pend = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vec = '0;
    logic          service_req, storm_event, timer_pending;
    logic [NP-1:0] rirr_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Row: {vector, pending, expect service, expect storm, expect flag}, pin 3
    localparam logic [11:0] TBL [9] = '{
        {8'h29, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h29, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h29, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h29, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h30, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h29, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h29, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h29, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h29, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    eoi_throttle_ctrl #(
        .NUM_PINS(NP), .VEC_W(8), .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY)
    ) i_eoi_throttle_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ent_wr(ent_wr), .ent_pin(ent_pin), .ent_vec(ent_vec), .ent_level(ent_level),
        .msk_wr(msk_wr), .msk_pin(msk_pin), .msk_val(msk_val),
        .rirr_set(rirr_set), .req_pend(req_pend),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
        .service_req(service_req), .storm_event(storm_event),
        .timer_pending(timer_pending), .rirr_out(rirr_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic wr_entry(int pin, logic [7:0] v, logic lvl);
        ent_wr = 1'b1; ent_pin = PW'(pin); ent_vec = v; ent_level = lvl;
        @(negedge clk);
        ent_wr = 1'b0;
    endtask

    task automatic wr_mask(int pin, logic m);
        msk_wr = 1'b1; msk_pin = PW'(pin); msk_val = m;
        @(negedge clk);
        msk_wr = 1'b0;
    endtask

    // Optionally flag the pin, then EOI; samples one cycle after the EOI edge.
    task automatic do_eoi(int pin, logic [7:0] v, logic p, logic flag,
                          output logic svc, output logic st, output logic rr);
        if (flag) begin
            rirr_set[pin] = 1'b1;
            @(negedge clk);
            rirr_set = '0;
        end
        req_pend[pin] = p;
        eoi_valid = 1'b1;
        eoi_vec = v;
        @(negedge clk);
        svc = service_req; st = storm_event; rr = rirr_out[pin];
        eoi_valid = 1'b0;
    endtask

    // Cycles from now until service_req is seen (limit 100).
    task automatic wait_service(output int d);
        int t0 = cyc;
        int n = 0;
        while (!service_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        d = cyc - t0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic svc, st, rr;
        int d;
        int extra;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 service", int'(service_req), 0);
        check("R9 storm", int'(storm_event), 0);
        check("R9 timer", int'(timer_pending), 0);
        check("R9 flags", int'(rirr_out), 0);

        // R10: configure entries
        wr_entry(3, 8'h29, 1'b1);  wr_mask(3, 1'b0);
        wr_entry(7, 8'h41, 1'b1);                      // stays masked
        wr_entry(20, 8'h29, 1'b0); wr_mask(20, 1'b0);  // edge trigger
        wr_entry(10, 8'h50, 1'b1); wr_mask(10, 1'b0);
        wr_entry(11, 8'h50, 1'b1); wr_mask(11, 1'b0);
        wr_entry(14, 8'h60, 1'b1); wr_mask(14, 1'b0);
        wr_entry(15, 8'h61, 1'b1); wr_mask(15, 1'b0);

        // R4 R5 R8: table walk on pin 3 with a vector above 23
        for (int r = 0; r < 9; r++) begin
            do_eoi(3, TBL[r][11:4], TBL[r][3], 1'b1, svc, st, rr);
            check($sformatf("R4 row %0d service", r), int'(svc), int'(TBL[r][2]));
            check($sformatf("R5 row %0d storm", r), int'(st), int'(TBL[r][1]));
            check($sformatf("R3 row %0d flag", r), int'(rr), int'(TBL[r][0]));
            if (TBL[r][1]) begin
                wait_service(d);
                check("R6 delay", d, DLY);
                @(negedge clk);
                check("R6 one pulse", int'(service_req), 0);
            end
        end

        // R1: edge-trigger pin with matching vector is skipped
        do_eoi(20, 8'h29, 1'b1, 1'b1, svc, st, rr);
        check("R1 edge flag kept", int'(rr), 1);
        check("R1 edge no service", int'(svc), 0);

        // R10 R9: entry left masked since reset, clears but no service
        do_eoi(7, 8'h41, 1'b1, 1'b1, svc, st, rr);
        check("R9 masked no service", int'(svc), 0);
        check("R9 masked flag cleared", int'(rr), 0);

        // R3: two pins share a vector, both cleared by one EOI
        rirr_set[10] = 1'b1; rirr_set[11] = 1'b1;
        @(negedge clk);
        rirr_set = '0;
        do_eoi(10, 8'h50, 1'b1, 1'b0, svc, st, rr);
        check("R3 pin10 cleared", int'(rr), 0);
        check("R3 pin11 cleared", int'(rirr_out[11]), 0);
        check("R4 shared service", int'(svc), 1);

        // R2: counts up to 3 on pin 14, then EOI with flag clear
        for (int k = 0; k < 3; k++) do_eoi(14, 8'h60, 1'b1, 1'b1, svc, st, rr);
        do_eoi(14, 8'h60, 1'b1, 1'b0, svc, st, rr);
        check("R2 no service", int'(svc), 0);
        check("R2 no storm", int'(st), 0);
        for (int k = 0; k < 3; k++) do_eoi(15, 8'h61, 1'b1, 1'b1, svc, st, rr);

        // R2 R7: count on pin 14 survived; storm, then second storm on pin 15
        do_eoi(14, 8'h60, 1'b1, 1'b1, svc, st, rr);
        check("R2 count kept storm", int'(st), 1);
        check("R5 no immediate", int'(svc), 0);
        d = cyc;
        repeat (5) @(negedge clk);
        do_eoi(15, 8'h61, 1'b1, 1'b1, svc, st, rr);
        check("R7 second storm", int'(st), 1);
        check("R7 timer still pending", int'(timer_pending), 1);
        begin
            int t1;
            wait_service(t1);
            check("R7 earlier expiry", cyc - d, DLY);
        end
        extra = 0;
        for (int k = 0; k < 2 * DLY; k++) begin
            @(negedge clk);
            if (service_req) extra++;
        end
        check("R7 single delayed request", extra, 0);
        check("R6 timer idle", int'(timer_pending), 0);

        finish_run();
    end
endmodule